// File: doc/BRIEF.md
# Pipelined Fixed-Point Dense Layer

This block evaluates one fully connected neural-network layer on 18-bit signed fixed-point data (8 integer bits, 10 fractional bits). Every output lane forms the dot product of the input vector with its own weight row, adds a per-lane bias, and then applies a per-lane scale and offset that hold a batch-normalization step folded into an affine map. It finishes by rounding, saturating and applying an activation function. Sums and products keep their full precision up to the final rounding step.

The block is fully pipelined. A new input vector can enter on every clock, and each result appears after a fixed number of cycles that is derived from the input count. A valid flag travels alongside the data, so layers can be cascaded by connecting one layer's output valid and vector to the next layer's inputs. The coefficients live in a small register file that is written through a single-word write port. A build-time mask marks pruned synapses. A pruned synapse gets no multiplier and no storage.

Top module: `dense_layer`

## Requirements
- R1: Input lane i sits in `in_vec[i*18 +: 18]` and output lane o sits in `out_vec[o*18 +: 18]`. Both are two's-complement values with 10 fractional bits. Output o equals act(sat(round((sum_i x_i*w_oi + b_o) * s_o + c_o))).
- R2: The weighted sum, the bias add, the scale product and the offset add are all exact. Rounding to 10 fractional bits happens once, at the end, to the nearest value, and an exact half rounds toward positive infinity.
- R3: A rounded result above 131071 (127.999) is clamped to 131071, and a result below -131072 is clamped to -131072.
- R4: With `LINEAR`=0, negative results become 0 (ReLU). With `LINEAR`=1, the saturated value passes through unchanged.
- R5: A vector is accepted on every cycle that `in_valid` is high, with no stall. `out_valid` repeats the `in_valid` sequence exactly LAT = ceil(log2(N_IN)) + 5 cycles later, and `out_vec` carries the matching result in those cycles.
- R6: After reset, `out_valid` is 0 and `out_vec` is all zeros. While `out_valid` is low, `out_vec` keeps the last result.
- R7: The configuration write address map is as follows:
  - weight (o,i) is at o*N_IN+i;
  - bias o is at N_OUT*N_IN+o;
  - scale o is at N_OUT*N_IN+N_OUT+o;
  - offset o is at N_OUT*N_IN+2*N_OUT+o.

  A write takes effect from the next clock. The reset values are: weights 0, biases 0, scales 1.0 (1024), offsets 0.
- R8: When bit o*N_IN+i of `PRUNE_MASK` is set, synapse (o,i) has no multiplier and contributes zero. A write to its weight address is ignored.
- R9: When N_IN is not a power of two, the adder tree is padded with zero leaves, and the latency still follows the R5 formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_vec | input | N_IN*18 | Packed input lanes |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | clog2(N_IN*N_OUT+3*N_OUT) | Coefficient address |
| cfg_wdata | input | 18 | Coefficient value |
| out_valid | output | 1 | Result present this cycle |
| out_vec | output | N_OUT*18 | Packed output lanes |

## Verification
The bench builds two instances that share the input and write buses.

The first instance has 8 inputs, 4 outputs and ReLU. Its prune mask removes 16 of the 32 synapses in an irregular pattern. This reaches the skipped multipliers, the ignored writes and the clamping of negative values to zero.

The second instance has 6 inputs, 4 outputs, a linear output and no pruning. This reaches the zero-padded adder tree, negative saturation and signed results.

Both instances have a latency of 8. Back-to-back streams, gapped streams, exact-half rounding cases and full-scale inputs are all checked against an integer model of the requirements.

// File: rtl/dense_pkg.sv
// dense_pkg: shared constants and helpers for the fixed-point dense layer.
// Assumes data words are 18-bit two's complement with 10 fractional bits.
package dense_pkg;
    localparam int DATA_W = 18;
    localparam int FRAC_W = 10;

    // Number of registered adder-tree levels for n leaves.
    function automatic int tree_levels(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

    // Cycles from input capture to output register: product, tree, four post stages.
    function automatic int layer_latency(input int n);
        return tree_levels(n) + 5;
    endfunction
endpackage

// File: rtl/dense_coef_regs.sv
// dense_coef_regs: register file for weights, biases, scales and offsets.
// Pruned weight slots have no storage and read as zero; writes to them are dropped.
// Assumes one write per cycle; out-of-range addresses change nothing.
module dense_coef_regs #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int W     = 18,
    parameter int F     = 10,
    parameter int AW    = 6,
    parameter logic [N_IN*N_OUT-1:0] PRUNE_MASK = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [W-1:0]        wdata,
    output logic signed [W-1:0] w_o     [N_IN*N_OUT],
    output logic signed [W-1:0] bias_o  [N_OUT],
    output logic signed [W-1:0] scale_o [N_OUT],
    output logic signed [W-1:0] offs_o  [N_OUT]
);
    localparam int NW = N_IN * N_OUT;
    localparam logic signed [W-1:0] ONE = W'(1 << F);

    for (genvar k = 0; k < NW; k++) begin : g_wgt
        if (PRUNE_MASK[k]) begin : g_pruned
            assign w_o[k] = '0;
        end else begin : g_live
            logic signed [W-1:0] r;
            // Holds one live weight; loads on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)                        r <= '0;
                else if (we && addr == AW'(k))     r <= wdata;
            end
            assign w_o[k] = r;

            // R7
            wgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == AW'(k)) |=> (w_o[k] == $past(wdata)));
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        logic signed [W-1:0] b_r, s_r, c_r;
        // Holds bias, scale and offset for one output lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_r <= '0;
                s_r <= ONE;
                c_r <= '0;
            end else if (we) begin
                if (addr == AW'(NW + o))             b_r <= wdata;
                if (addr == AW'(NW + N_OUT + o))     s_r <= wdata;
                if (addr == AW'(NW + 2 * N_OUT + o)) c_r <= wdata;
            end
        end
        assign bias_o[o]  = b_r;
        assign scale_o[o] = s_r;
        assign offs_o[o]  = c_r;

        // R7
        scale_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == AW'(NW + N_OUT + o)) |=> (scale_o[o] == $past(wdata)));
    end
endmodule

// File: rtl/dense_adder_tree.sv
// dense_adder_tree: pipelined binary adder tree, one adder level per stage.
// Leaves are padded to a power of two with zeros; sums grow one bit per level,
// so no precision is lost. Assumes L = ceil(log2(N)) (0 when N is 1).
module dense_adder_tree #(
    parameter int N  = 8,
    parameter int IW = 36,
    parameter int L  = 3,
    parameter int OW = IW + L
) (
    input  logic                 clk,
    input  logic signed [IW-1:0] leaf [N],
    output logic signed [OW-1:0] sum
);
    for (genvar lev = 0; lev <= L; lev++) begin : g_lvl
        localparam int CNT = 1 << (L - lev);
        logic signed [OW-1:0] s [CNT];
        if (lev == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_pad
                if (j < N) begin : g_real
                    assign s[j] = OW'(leaf[j]);
                end else begin : g_zero
                    assign s[j] = '0;
                end
            end
        end else begin : g_node
            // One registered level of pairwise sums.
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++)
                    s[j] <= g_lvl[lev-1].s[2*j] + g_lvl[lev-1].s[2*j+1];
            end
        end
    end

    assign sum = g_lvl[L].s[0];
endmodule

// File: rtl/dense_post.sv
// dense_post: per-lane tail of the layer: bias add, scale multiply, offset add,
// then round-half-up, saturate and activation. Four stages, one operation each.
// Assumes the bias and offset are in the data format, and scale has F fractional bits.
// The output register loads only when en marks a valid word in the last stage.
module dense_post #(
    parameter int W      = 18,
    parameter int F      = 10,
    parameter int SW     = 39,
    parameter bit LINEAR = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] sum,
    input  logic signed [W-1:0]  bias,
    input  logic signed [W-1:0]  scale,
    input  logic signed [W-1:0]  offs,
    output logic signed [W-1:0]  y
);
    localparam int BW = SW + 1;
    localparam int MW = BW + W;
    localparam int OW = MW + 2;
    localparam logic signed [W-1:0]  YMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0]  YMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [OW-1:0] MAXV = OW'(YMAX);
    localparam logic signed [OW-1:0] MINV = OW'(YMIN);
    localparam logic signed [OW-1:0] HALF = OW'(1) <<< (2 * F - 1);

    logic signed [BW-1:0] b_r;
    logic signed [MW-1:0] m_r;
    logic signed [OW-1:0] t_r;
    logic signed [OW-1:0] rnd, rq;
    logic signed [W-1:0]  sat, nxt;

    // Exact arithmetic stages: bias, scale, offset.
    always_ff @(posedge clk) begin
        b_r <= BW'(sum) + (BW'(bias) <<< F);
        m_r <= MW'(b_r) * MW'(scale);
        t_r <= OW'(m_r) + (OW'(offs) <<< (2 * F));
    end

    // Round to F fractional bits, clamp, then activation.
    always_comb begin
        rnd = t_r + HALF;
        rq  = rnd >>> (2 * F);
        if (rq > MAXV)      sat = YMAX;
        else if (rq < MINV) sat = YMIN;
        else                sat = rq[W-1:0];
        nxt = (!LINEAR && sat[W-1]) ? '0 : sat;
    end

    // Output register; holds its value between valid words.
    always_ff @(posedge clk) begin
        if (!rst_n)  y <= '0;
        else if (en) y <= nxt;
    end

    // R3
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rq > MAXV) |=> (y == YMAX));
    // R3
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && LINEAR && rq < MINV) |=> (y == YMIN));
    // R4
    relu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !LINEAR && rq < 0) |=> (y == '0));
endmodule

// File: rtl/dense_layer.sv
// dense_layer: fully pipelined fixed-point dense layer with folded normalization.
// One vector in per clock, one result per clock after LAT cycles, no backpressure.
// Synapses flagged in PRUNE_MASK have no multiplier. Assumes that coefficients
// are not rewritten while vectors are in flight.
module dense_layer #(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 4,
    parameter int W      = dense_pkg::DATA_W,
    parameter int F      = dense_pkg::FRAC_W,
    parameter bit LINEAR = 1'b0,
    parameter logic [N_IN*N_OUT-1:0] PRUNE_MASK = '0,
    localparam int NREG  = N_IN * N_OUT + 3 * N_OUT,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N_IN*W-1:0]   in_vec,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [W-1:0]        cfg_wdata,
    output logic                out_valid,
    output logic [N_OUT*W-1:0]  out_vec
);
    localparam int L   = dense_pkg::tree_levels(N_IN);
    localparam int LAT = dense_pkg::layer_latency(N_IN);
    localparam int PW  = 2 * W;
    localparam int SW  = PW + L;
    localparam int NW  = N_IN * N_OUT;
    localparam int CW  = $clog2(LAT + 2) + 1;

    logic signed [W-1:0] x       [N_IN];
    logic signed [W-1:0] w       [NW];
    logic signed [W-1:0] bias    [N_OUT];
    logic signed [W-1:0] scale   [N_OUT];
    logic signed [W-1:0] offs    [N_OUT];
    logic [LAT-1:0]      vpipe;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign x[i] = in_vec[i*W +: W];
    end

    dense_coef_regs #(
        .N_IN(N_IN), .N_OUT(N_OUT), .W(W), .F(F), .AW(AW), .PRUNE_MASK(PRUNE_MASK)
    ) u_coef (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .w_o(w), .bias_o(bias), .scale_o(scale), .offs_o(offs)
    );

    // Valid shift register that tracks the data pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end
    assign out_valid = vpipe[LAT-1];

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic signed [PW-1:0] p [N_IN];
        logic signed [SW-1:0] s;
        logic signed [W-1:0]  y;

        for (genvar i = 0; i < N_IN; i++) begin : g_syn
            if (PRUNE_MASK[o*N_IN+i]) begin : g_skip
                assign p[i] = '0;
            end else begin : g_mul
                logic signed [PW-1:0] pr;
                // Registered full-width product for one live synapse.
                always_ff @(posedge clk) pr <= PW'(x[i]) * PW'(w[o*N_IN+i]);
                assign p[i] = pr;
            end
        end

        dense_adder_tree #(.N(N_IN), .IW(PW), .L(L), .OW(SW)) u_tree (
            .clk(clk), .leaf(p), .sum(s)
        );

        dense_post #(.W(W), .F(F), .SW(SW), .LINEAR(LINEAR)) u_post (
            .clk(clk), .rst_n(rst_n), .en(vpipe[LAT-2]), .sum(s),
            .bias(bias[o]), .scale(scale[o]), .offs(offs[o]), .y(y)
        );

        assign out_vec[o*W +: W] = y;
    end

    // Checker state: cycles since reset (saturating) and vectors in flight.
    logic [CW-1:0] cyc, inflight;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= '0;
            inflight <= '0;
        end else begin
            if (cyc < CW'(LAT)) cyc <= cyc + 1'b1;
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    // R5
    early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < CW'(LAT)) |-> !out_valid);
    // R5
    inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(LAT));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_vec));
endmodule

// File: tb/dense_layer_tb.sv
// dense_layer_tb: directed bench with two layer instances on shared buses and an
// integer reference model evaluated when each vector is driven.
module dense_layer_tb;
    localparam int LAT = 8;                  // R5: ceil(log2(8))+5 and ceil(log2(6))+5
    localparam logic [31:0] MASK_A = 32'hA5A55A5A;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [8*18-1:0] in_vec = '0;
    logic we_a = 1'b0, we_b = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic out_valid_a, out_valid_b;
    logic [71:0] out_vec_a, out_vec_b;

    always #10 clk = ~clk;

    dense_layer #(.N_IN(8), .N_OUT(4), .LINEAR(1'b0), .PRUNE_MASK(MASK_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .cfg_we(we_a), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid_a), .out_vec(out_vec_a));

    dense_layer #(.N_IN(6), .N_OUT(4), .LINEAR(1'b1), .PRUNE_MASK(24'h0)) u_dut_lin (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec[6*18-1:0]),
        .cfg_we(we_b), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid_b), .out_vec(out_vec_b));

    // Shadow coefficients (R7 reset values).
    longint wa [4][8], wb [4][6];
    longint ba [4], sa [4], ca [4], bb [4], sb [4], cb [4];
    longint xv [8];
    int n_chk = 0, n_err = 0, sb_chk = 0, sb_err = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // Reference per lane: R1 formula, R2 rounding, R3 clamp, R4 activation.
    function automatic logic [17:0] lane_ref(input bit lin, input longint acc,
                                             input longint b, input longint s, input longint c);
        longint t, r;
        t = (acc + b * 1024) * s + c * 1048576;
        r = (t + 524288) >>> 20;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        if (!lin && r < 0) r = 0;
        return r[17:0];
    endfunction

    // Scoreboard: expected entries travel LAT stages; compare at the far end.
    logic        pv [0:LAT];
    logic [71:0] ea [0:LAT], eb [0:LAT];
    string       ptag [0:LAT];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= LAT; k++) pv[k] = 1'b0;
        end else begin
            for (int k = LAT; k > 0; k--) begin
                pv[k] = pv[k-1]; ea[k] = ea[k-1]; eb[k] = eb[k-1]; ptag[k] = ptag[k-1];
            end
            if (pv[LAT] || out_valid_a) begin
                sb_chk++;
                if (out_valid_a !== pv[LAT] || (pv[LAT] && out_vec_a !== ea[LAT])) begin
                    sb_err++;
                    $display("FAIL %s (R5 relu unit): valid=%b vec=%h exp valid=%b vec=%h",
                             ptag[LAT], out_valid_a, out_vec_a, pv[LAT], ea[LAT]);
                end
            end
            if (pv[LAT] || out_valid_b) begin
                sb_chk++;
                if (out_valid_b !== pv[LAT] || (pv[LAT] && out_vec_b !== eb[LAT])) begin
                    sb_err++;
                    $display("FAIL %s (R9 linear unit): valid=%b vec=%h exp valid=%b vec=%h",
                             ptag[LAT], out_valid_b, out_vec_b, pv[LAT], eb[LAT]);
                end
            end
            pv[0] = in_valid;
            ptag[0] = cur_tag;
            for (int o = 0; o < 4; o++) begin
                longint acc_a, acc_b, xi;
                acc_a = 0; acc_b = 0;
                for (int i = 0; i < 8; i++) begin
                    xi = longint'(signed'(in_vec[i*18 +: 18]));
                    acc_a += xi * wa[o][i];
                    if (i < 6) acc_b += xi * wb[o][i];
                end
                ea[0][o*18 +: 18] = lane_ref(1'b0, acc_a, ba[o], sa[o], ca[o]);
                eb[0][o*18 +: 18] = lane_ref(1'b1, acc_b, bb[o], sb[o], cb[o]);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // One write to one instance; shadow follows R7 map and R8 pruning.
    task automatic cfg_wr(input bit to_b, input int addr, input longint val);
        int ni, nw;
        @(posedge clk); #2;
        we_a = !to_b; we_b = to_b; cfg_addr = 6'(addr); cfg_wdata = val[17:0];
        ni = to_b ? 6 : 8;
        nw = 4 * ni;
        if (addr < nw) begin
            if (to_b) wb[addr / ni][addr % ni] = val;
            else if (!MASK_A[addr]) wa[addr / ni][addr % ni] = val;
        end else if (addr < nw + 4) begin
            if (to_b) bb[addr - nw] = val; else ba[addr - nw] = val;
        end else if (addr < nw + 8) begin
            if (to_b) sb[addr - nw - 4] = val; else sa[addr - nw - 4] = val;
        end else if (addr < nw + 12) begin
            if (to_b) cb[addr - nw - 8] = val; else ca[addr - nw - 8] = val;
        end
        @(posedge clk); #2;
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic wr_w(input int o, input int i, input longint val);
        cfg_wr(1'b0, o * 8 + i, val);
        if (i < 6) cfg_wr(1'b1, o * 6 + i, val);
    endtask

    task automatic wr_bn(input int o, input longint b, input longint s, input longint c);
        cfg_wr(1'b0, 32 + o, b); cfg_wr(1'b0, 36 + o, s); cfg_wr(1'b0, 40 + o, c);
        cfg_wr(1'b1, 24 + o, b); cfg_wr(1'b1, 28 + o, s); cfg_wr(1'b1, 32 + o, c);
    endtask

    task automatic send(input bit v);
        @(posedge clk); #2;
        in_valid = v;
        for (int i = 0; i < 8; i++) in_vec[i*18 +: 18] = xv[i][17:0];
    endtask

    task automatic drain();
        @(posedge clk); #2;
        in_valid = 1'b0;
        repeat (LAT + 2) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid_a == 1'b0 && out_valid_b == 1'b0, "R6 reset valid",
              {out_valid_a, out_valid_b}, 0);
        check(out_vec_a == '0 && out_vec_b == '0, "R6 reset vector", out_vec_a[63:0], 0);
    endtask

    task automatic t_defaults();
        cur_tag = "R7 R8 R9 defaults";
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++) wr_w(o, i, ((o * 5 + i * 3) % 11 - 5) * 256);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 8; i++) xv[i] = k * 300 + i * 150 - 900;
            send(1'b1);
        end
        drain();
    endtask

    task automatic t_stream();
        cur_tag = "R1 R5 stream";
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 8; i++) xv[i] = (k * 7919 + i * 104729) % 60000 - 30000;
            send(1'b1);
        end
        drain();
    endtask

    task automatic t_bn();
        cur_tag = "R2 normalization";
        wr_bn(0, 300, 768, -1000);
        wr_bn(1, -2000, -1536, 700);
        wr_bn(2, 0, 2048, 0);
        wr_bn(3, 5000, 128, 12345);
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) xv[i] = (k * 3001 + i * 977) % 9000 - 4500;
            send(1'b1);
        end
        drain();
    endtask

    task automatic t_round();
        cur_tag = "R2 rounding";
        for (int o = 0; o < 4; o++) begin
            wr_bn(o, 0, 1024, 0);
            for (int i = 0; i < 8; i++) wr_w(o, i, 512);
        end
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) xv[i] = 0;
            case (k)
                0: xv[0] = 1;
                1: xv[0] = -1;
                2: begin xv[1] = 1; xv[2] = 1; end
                3: begin xv[0] = -3; xv[5] = 1; end
                4: for (int i = 0; i < 8; i++) xv[i] = 1;
                default: for (int i = 0; i < 8; i++) xv[i] = -1;
            endcase
            send(1'b1);
        end
        drain();
    endtask

    task automatic t_sat();
        cur_tag = "R3 R4 saturation";
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++) wr_w(o, i, 131071);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++)
                xv[i] = (k == 0) ? 131071 : (k == 1) ? -131072 : ((i % 2) ? 131071 : -131072);
            send(1'b1);
        end
        drain();
    endtask

    task automatic t_prune();
        cur_tag = "R8 pruned write";
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++) wr_w(o, i, 0);
        wr_w(0, 1, 20000);   // pruned in the ReLU instance (mask bit 1), live in the other
        wr_w(2, 0, 20000);   // pruned in the ReLU instance (mask bit 16)
        for (int i = 0; i < 8; i++) xv[i] = 0;
        xv[1] = 4096;
        send(1'b1);
        xv[1] = 0; xv[0] = 4096;
        send(1'b1);
        drain();
    endtask

    task automatic t_gaps();
        bit pat [11] = '{1, 0, 1, 1, 0, 0, 1, 0, 1, 1, 1};
        cur_tag = "R5 gapped stream";
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++) wr_w(o, i, (o + 1) * 300 - i * 200);
        for (int k = 0; k < 11; k++) begin
            for (int i = 0; i < 8; i++) xv[i] = k * 1100 - i * 700;
            send(pat[k]);
        end
        drain();
    endtask

    task automatic t_hold();
        logic [71:0] ha, hb;
        @(negedge clk);
        ha = out_vec_a; hb = out_vec_b;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!out_valid_a && !out_valid_b, "R6 idle valid", {out_valid_a, out_valid_b}, 0);
            check(out_vec_a == ha && out_vec_b == hb, "R6 hold vector", out_vec_a[63:0], ha[63:0]);
        end
    endtask

    initial begin
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 8; i++) wa[o][i] = 0;
            for (int i = 0; i < 6; i++) wb[o][i] = 0;
            ba[o] = 0; sa[o] = 1024; ca[o] = 0;
            bb[o] = 0; sb[o] = 1024; cb[o] = 0;
        end
        for (int i = 0; i < 8; i++) xv[i] = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_defaults();
        t_stream();
        t_bn();
        t_round();
        t_sat();
        t_prune();
        t_gaps();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err + sb_err, n_chk + sb_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", n_err + sb_err + 1, n_chk + sb_chk + 1);
            $finish;
        end
    end
endmodule